// File: doc/BRIEF.md
# Two-Bank Skewed Cache Tag Array with Lookahead Relocation

This block holds the tag side of a two-way cache whose ways are two separate banks, each indexed by its own hash of the block address. Two addresses that collide in one bank usually land in different sets of the other bank. This spreads conflicts that a plain two-way cache would keep. Each entry stores a valid bit, the full block address and a small allocation timestamp. No data is stored.

A request presents a block address. The response comes one cycle later and says whether the address was resident. On a hit, the line's timestamp is refreshed. On a miss, the new address is always installed. Before anything is written, the block looks ahead at four possible victims:

- the two direct slots;
- the slot in the opposite bank that each direct occupant could be moved into.

If the chosen victim sits in an alternate slot, the direct occupant moves there in the same cycle that the new address is written. Any block pushed out of the array is reported on the victim output, so the surrounding cache can write it back or drop it.

Top module: `skew_cache_tags`

## Requirements
- R1: While reset is high and in the cycle after it, resp_valid and evict_valid are 0. After reset, every stored entry is invalid, so the first lookup of any address misses.
- R2: The bank 0 set index is addr[3:0]. The bank 1 set index is addr[3:0] XOR addr[7:4]. Two addresses with equal bank 0 index but different bank 1 index can both be resident at once.
- R3: A request accepted on a clock edge gives resp_valid=1 in the following cycle. resp_hit is 1 exactly when the address is stored in its bank 0 slot or its bank 1 slot. A hit never reports a victim.
- R4: A missing address is installed, so an immediately following request for it hits. The victim reported is never the requested address itself.
- R5: On a miss, candidates are numbered as follows:
  - 0 is the bank 0 direct slot;
  - 1 is the bank 1 direct slot;
  - 2 moves the bank 0 occupant to its bank 1 slot;
  - 3 moves the bank 1 occupant to its bank 0 slot.

  If any candidate's receiving slot is empty, the lowest-numbered such candidate is used and evict_valid is 0.
- R6: With no empty candidate, the candidate whose displaced entry has the largest age is used. Age is (counter − stamp) mod 32. On equal age, the lower candidate number wins. The displaced entry's address appears on evict_addr with evict_valid=1.
- R7: For candidates 2 and 3, the moved entry stays resident with its stamp unchanged. A later lookup of it hits.
- R8: A hit rewrites the line's stamp with the current counter value. This makes the line younger for later victim choices.
- R9: The 5-bit allocation counter stamps each new entry with its current value. It then advances by one per miss and wraps. It holds on hits and idle cycles.
- R10: A cycle with req_valid=0 gives resp_valid=0 next cycle and changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup/fill request strobe |
| req_addr | input | 12 | Block address of the request |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_hit | output | 1 | 1 when that address was resident |
| evict_valid | output | 1 | A resident entry was pushed out by the fill |
| evict_addr | output | 12 | Address of the pushed-out entry |

## Verification
Directed cases come first:
- a lookup straight out of reset, which tells a cleared array from stale state;
- a pair of addresses sharing a bank 0 set but not a bank 1 set, which tells two hashed banks from a shared index;
- idle cycles, which tell a held state from a spurious response.

The main run then draws addresses at random from a pool whose bank 0 indices crowd into four sets. This forces steady misses, relocations and counter wrap. A bench model built from the requirements predicts every hit, victim and victim address. Each mismatch separates errors in:
- candidate ordering;
- age comparison across wrap;
- stamp refresh on hits;
- keeping moved entries resident.

// File: rtl/skew_cache_pkg.sv
package skew_cache_pkg;
    parameter int ADDR_W = 12;
    parameter int IDX_W  = 4;
    parameter int TS_W   = 5;
    localparam int SETS  = 1 << IDX_W;
    localparam int NCAND = 4;
    localparam int CAND_W = $clog2(NCAND);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TS_W-1:0]   ts_t;
    typedef logic [CAND_W-1:0] cand_t;

    typedef struct packed {
        logic  valid;
        addr_t addr;
        ts_t   ts;
    } line_t;

    // Bank 0 uses the low index bits; bank 1 folds in the next field.
    function automatic idx_t bank_index(input int bank, input addr_t a);
        if (bank == 0) return a[IDX_W-1:0];
        return a[IDX_W-1:0] ^ a[2*IDX_W-1:IDX_W];
    endfunction

    // Modular distance from a stamp to the running counter.
    function automatic ts_t age_of(input ts_t now, input ts_t stamp);
        return ts_t'(now - stamp);
    endfunction
endpackage

// File: rtl/skew_cache_bank.sv
module skew_cache_bank
    import skew_cache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  dir_idx,
    output line_t dir_line,
    input  idx_t  alt_idx,
    output line_t alt_line,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  line_t wr_line
);
    line_t mem [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) mem[s] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_line;
        end
    end

    assign dir_line = mem[dir_idx];
    assign alt_line = mem[alt_idx];
endmodule

// File: rtl/skew_cache_victim_sel.sv
module skew_cache_victim_sel
    import skew_cache_pkg::*;
(
    input  logic [NCAND-1:0]           cand_free,
    input  logic [NCAND-1:0][TS_W-1:0] cand_age,
    output cand_t                      pick
);
    always_comb begin
        logic found;
        ts_t  best;
        found = 1'b0;
        pick  = '0;
        best  = '0;
        for (int k = 0; k < NCAND; k++) begin
            if (cand_free[k] && !found) begin
                found = 1'b1;
                pick  = cand_t'(k);
            end
        end
        if (!found) begin
            best = cand_age[0];
            pick = '0;
            for (int k = 1; k < NCAND; k++) begin
                if (cand_age[k] > best) begin
                    best = cand_age[k];
                    pick = cand_t'(k);
                end
            end
        end
    end
endmodule

// File: rtl/skew_cache_tags.sv
module skew_cache_tags
    import skew_cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr
);
    ts_t   alloc_cnt;
    idx_t  dir_idx  [2];
    idx_t  alt_idx  [2];
    idx_t  wr_idx   [2];
    line_t dir_line [2];
    line_t alt_line [2];
    line_t wr_line  [2];
    logic  wr_en    [2];
    logic [1:0]                 hit_vec;
    logic [NCAND-1:0]           cand_free;
    logic [NCAND-1:0][TS_W-1:0] cand_age;
    cand_t pick;
    logic  miss;
    logic  vict_valid;
    addr_t vict_addr;
    line_t fresh;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_bank
            assign dir_idx[g] = bank_index(g, req_addr);
            // Slot the opposite bank's direct occupant would move into.
            assign alt_idx[g] = bank_index(g, dir_line[1-g].addr);

            assign hit_vec[g] = req_valid && dir_line[g].valid
                                && (dir_line[g].addr == req_addr);

            assign cand_free[g]   = !dir_line[g].valid;
            assign cand_age[g]    = age_of(alloc_cnt, dir_line[g].ts);
            assign cand_free[2+g] = dir_line[g].valid && !alt_line[1-g].valid;
            assign cand_age[2+g]  = dir_line[g].valid
                                    ? age_of(alloc_cnt, alt_line[1-g].ts) : '0;

            skew_cache_bank u_bank (
                .clk      (clk),
                .rst      (rst),
                .dir_idx  (dir_idx[g]),
                .dir_line (dir_line[g]),
                .alt_idx  (alt_idx[g]),
                .alt_line (alt_line[g]),
                .wr_en    (wr_en[g]),
                .wr_idx   (wr_idx[g]),
                .wr_line  (wr_line[g])
            );
        end
    endgenerate

    skew_cache_victim_sel u_sel (
        .cand_free (cand_free),
        .cand_age  (cand_age),
        .pick      (pick)
    );

    assign miss  = req_valid && (hit_vec == 2'b00);
    assign fresh = '{valid: 1'b1, addr: req_addr, ts: alloc_cnt};

    always_comb begin
        for (int b = 0; b < 2; b++) begin
            wr_en[b]   = 1'b0;
            wr_idx[b]  = dir_idx[b];
            wr_line[b] = fresh;
        end
        vict_valid = 1'b0;
        vict_addr  = '0;
        if (req_valid && (hit_vec != 2'b00)) begin
            for (int b = 0; b < 2; b++) wr_en[b] = hit_vec[b];
        end else if (miss) begin
            unique case (pick)
                2'd0: begin
                    wr_en[0]   = 1'b1;
                    vict_valid = dir_line[0].valid;
                    vict_addr  = dir_line[0].addr;
                end
                2'd1: begin
                    wr_en[1]   = 1'b1;
                    vict_valid = dir_line[1].valid;
                    vict_addr  = dir_line[1].addr;
                end
                2'd2: begin
                    wr_en[0]   = 1'b1;
                    wr_en[1]   = 1'b1;
                    wr_idx[1]  = alt_idx[1];
                    wr_line[1] = dir_line[0];
                    vict_valid = alt_line[1].valid;
                    vict_addr  = alt_line[1].addr;
                end
                default: begin
                    wr_en[1]   = 1'b1;
                    wr_en[0]   = 1'b1;
                    wr_idx[0]  = alt_idx[0];
                    wr_line[0] = dir_line[1];
                    vict_valid = alt_line[0].valid;
                    vict_addr  = alt_line[0].addr;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            evict_valid <= 1'b0;
            evict_addr  <= '0;
            alloc_cnt   <= '0;
        end else begin
            resp_valid  <= req_valid;
            resp_hit    <= |hit_vec;
            evict_valid <= vict_valid;
            evict_addr  <= vict_addr;
            if (miss) alloc_cnt <= ts_t'(alloc_cnt + 1'b1);
        end
    end
endmodule

// File: rtl/skew_cache_tags_chk.sv
module skew_cache_tags_chk
    import skew_cache_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  req_valid,
    input addr_t req_addr,
    input logic  resp_valid,
    input logic  resp_hit,
    input logic  evict_valid,
    input addr_t evict_addr,
    input ts_t   alloc_cnt
);
    a_r3_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    a_r10_idle_no_resp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    a_r3_hit_no_victim: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> !evict_valid);

    a_r6_victim_only_on_miss: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> (resp_valid && !resp_hit));

    a_r4_victim_not_request: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!evict_valid || evict_addr != $past(req_addr)));

    a_r9_count_on_miss: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> alloc_cnt == ts_t'($past(alloc_cnt) + 1'b1));

    a_r9_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
        !(resp_valid && !resp_hit) |-> $stable(alloc_cnt));
endmodule

bind skew_cache_tags skew_cache_tags_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .evict_valid (evict_valid),
    .evict_addr  (evict_addr),
    .alloc_cnt   (alloc_cnt)
);

// File: tb/tb_skew_cache_tags.sv
module tb_skew_cache_tags;
    import skew_cache_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  req_valid = 1'b0;
    addr_t req_addr = '0;
    logic  resp_valid, resp_hit, evict_valid;
    addr_t evict_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    skew_cache_tags dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_addr (req_addr),
        .resp_valid (resp_valid), .resp_hit (resp_hit),
        .evict_valid (evict_valid), .evict_addr (evict_addr)
    );

    // Reference state built from the requirements.
    logic  m_v [2][SETS];
    addr_t m_a [2][SETS];
    ts_t   m_t [2][SETS];
    ts_t   m_cnt;

    function automatic idx_t ref_idx(input int b, input addr_t a);
        return (b == 0) ? a[3:0] : (a[3:0] ^ a[7:4]);
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < SETS; s++) begin
                m_v[b][s] = 1'b0; m_a[b][s] = '0; m_t[b][s] = '0;
            end
        m_cnt = '0;
    endtask

    task automatic model_access(input addr_t a, output logic eh,
                                output logic ev, output addr_t ea);
        idx_t i [2];
        idx_t j [2];
        logic fr [4];
        ts_t  ag [4];
        int   c;
        ts_t  best;
        logic found;
        i[0] = ref_idx(0, a);
        i[1] = ref_idx(1, a);
        eh = 1'b0; ev = 1'b0; ea = '0;
        for (int b = 0; b < 2; b++)
            if (m_v[b][i[b]] && m_a[b][i[b]] == a) begin
                eh = 1'b1;
                m_t[b][i[b]] = m_cnt;
            end
        if (eh) return;
        j[1] = ref_idx(1, m_a[0][i[0]]);
        j[0] = ref_idx(0, m_a[1][i[1]]);
        fr[0] = !m_v[0][i[0]];
        fr[1] = !m_v[1][i[1]];
        fr[2] = m_v[0][i[0]] && !m_v[1][j[1]];
        fr[3] = m_v[1][i[1]] && !m_v[0][j[0]];
        ag[0] = ts_t'(m_cnt - m_t[0][i[0]]);
        ag[1] = ts_t'(m_cnt - m_t[1][i[1]]);
        ag[2] = ts_t'(m_cnt - m_t[1][j[1]]);
        ag[3] = ts_t'(m_cnt - m_t[0][j[0]]);
        found = 1'b0; c = 0;
        for (int k = 0; k < 4; k++)
            if (fr[k] && !found) begin found = 1'b1; c = k; end
        if (!found) begin
            best = ag[0]; c = 0;
            for (int k = 1; k < 4; k++)
                if (ag[k] > best) begin best = ag[k]; c = k; end
        end
        case (c)
            0: begin ev = m_v[0][i[0]]; ea = m_a[0][i[0]]; end
            1: begin ev = m_v[1][i[1]]; ea = m_a[1][i[1]]; end
            2: begin
                ev = m_v[1][j[1]]; ea = m_a[1][j[1]];
                m_v[1][j[1]] = 1'b1; m_a[1][j[1]] = m_a[0][i[0]];
                m_t[1][j[1]] = m_t[0][i[0]];
            end
            default: begin
                ev = m_v[0][j[0]]; ea = m_a[0][j[0]];
                m_v[0][j[0]] = 1'b1; m_a[0][j[0]] = m_a[1][i[1]];
                m_t[0][j[0]] = m_t[1][i[1]];
            end
        endcase
        if (c == 0 || c == 2) begin
            m_v[0][i[0]] = 1'b1; m_a[0][i[0]] = a; m_t[0][i[0]] = m_cnt;
        end else begin
            m_v[1][i[1]] = 1'b1; m_a[1][i[1]] = a; m_t[1][i[1]] = m_cnt;
        end
        m_cnt = ts_t'(m_cnt + 1'b1);
    endtask

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic do_req(input addr_t a, output logic got_hit);
        logic eh, ev;
        addr_t ea;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        model_access(a, eh, ev, ea);
        got_hit = resp_hit;
        chk(resp_valid == 1'b1, "R3 resp_valid", 32'(resp_valid), 32'd1);
        chk(resp_hit == eh, "R3 R7 R8 resp_hit", 32'(resp_hit), 32'(eh));
        chk(evict_valid == ev, "R5 R6 evict_valid", 32'(evict_valid), 32'(ev));
        if (ev)
            chk(evict_addr == ea, "R6 R9 evict_addr", 32'(evict_addr), 32'(ea));
    endtask

    task automatic do_idle();
        req_valid = 1'b0;
        @(negedge clk);
        chk(resp_valid == 1'b0, "R10 idle resp_valid", 32'(resp_valid), 32'd0);
        chk(evict_valid == 1'b0, "R10 idle evict_valid", 32'(evict_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic h;
        addr_t last;
        void'($urandom(32'h0005eed5));
        model_reset();
        repeat (3) @(negedge clk);
        chk(resp_valid == 1'b0, "R1 reset resp_valid", 32'(resp_valid), 32'd0);
        chk(evict_valid == 1'b0, "R1 reset evict_valid", 32'(evict_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(resp_valid == 1'b0, "R1 post-reset resp_valid", 32'(resp_valid), 32'd0);

        // R1/R4: first lookup misses, then hits.
        do_req(12'h005, h);
        chk(h == 1'b0, "R1 first lookup miss", 32'(h), 32'd0);
        do_req(12'h005, h);
        chk(h == 1'b1, "R4 refill hit", 32'(h), 32'd1);
        do_idle();

        // R2: shared bank 0 set, different bank 1 set; both stay resident.
        do_req(12'h015, h);
        chk(h == 1'b0, "R2 second address miss", 32'(h), 32'd0);
        do_req(12'h005, h);
        chk(h == 1'b1, "R2 first still resident", 32'(h), 32'd1);
        do_req(12'h015, h);
        chk(h == 1'b1, "R2 second resident", 32'(h), 32'd1);
        do_idle();
        do_idle();

        // Crowded random run: relocation, age order, refresh, wrap.
        last = '0;
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 8) == 0) begin
                do_idle();
            end else begin
                addr_t a;
                a = {2'b00, 2'($urandom), 4'($urandom), 2'b00, 2'($urandom)};
                do_req(a, h);
                last = a;
            end
        end

        // R1: a second reset empties the array.
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        do_req(last, h);
        chk(h == 1'b0, "R1 miss after second reset", 32'(h), 32'd0);
        req_valid = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule